// File: doc/BRIEF.md
# Software-Sequence Store/Recall Detector

This block watches the read traffic of an SRAM-style access port. It recognises a fixed series of six consecutive read addresses and turns that series into a one-cycle command. A completed series asks the neighbouring control logic to copy the array into nonvolatile storage (store) or to copy it back (recall). Every access is presented as a single-cycle strobe together with a select, a write flag and an address.

The first five addresses are shared by both commands. The sixth address decides which command is issued. The detector is a six-state machine, and each state records how many keys have matched so far:

| State | Meaning |
|---|---|
| `ST_IDLE` | No progress |
| `ST_GOT1` to `ST_GOT5` | One to five prefix keys have matched |

The machine has these transitions:

| Transition | Taken when | Result |
|---|---|---|
| advance | a read matches the next prefix key | move to the next state |
| restart | a read mismatches but equals the first key | go to `ST_GOT1` |
| drop | a read mismatches and is not the first key | go to `ST_IDLE` |
| abort | any selected write | go to `ST_IDLE` |
| fire-store | in `ST_GOT5`, a read matches the store key | issue a store request, go to `ST_IDLE` |
| fire-recall | in `ST_GOT5`, a read matches the recall key | issue a recall request, go to `ST_IDLE` |
| hold | no selected strobe | stay in the current state |

Top module: `seqcmd_detect`

## Requirements
- R1: Six selected reads whose low 14 address bits are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0, in that order, raise `store_req` for exactly the cycle after the sixth strobe's clock edge.
- R2: The same five-key prefix followed by 0x0C63 raises `recall_req` in the same way.
- R3: Address bit 14 never affects matching. Only bits 13:0 are compared.
- R4: A selected strobe with `wr` high resets progress to idle. `seq_busy` is low in the following cycle and no request is issued.
- R5: A selected read that does not match the expected next key breaks the series. If that read equals 0x0E38, it counts as the first key of a new series and `seq_busy` stays high. Otherwise the detector goes idle.
- R6: Clock cycles without a strobe, and strobes with `sel` low, leave progress unchanged and issue no request.
- R7: `seq_busy` is high, one cycle after a clock edge, exactly when one to five keys of a series have matched.
- R8: A request lasts one cycle, `store_req` and `recall_req` are never high together, and `seq_busy` is low while either is high.
- R9: A synchronous active-low `rst_n` clears progress and both requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb | input | 1 | One-cycle marker of an access |
| sel | input | 1 | Chip select, active high |
| wr | input | 1 | High for a write access, low for a read |
| addr | input | 15 | Access address; bits 13:0 are compared |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |
| seq_busy | output | 1 | A series is partly matched |

## Verification
The bench goes after the following corner cases:

- **Restart on a repeated first key.** A design that dropped to idle here would lose a sequence that software re-issues.
- **A wrong sixth address.** Treating it as a match would raise a command that was never requested.
- **Writes and deselected strobes in the middle of a series.** A design that ignores the write would fire falsely. A design that resets on a deselected strobe would miss a valid command.
- **Address bit 14 set.** A design that compared all 15 bits would never fire.

Random traffic is biased toward the expected next key, so long partial series and back-to-back series occur often. Random writes and deselects are mixed in with that traffic.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int KEY_W   = 14;
    localparam int N_PRE   = 5;
    localparam int N_KEYS  = N_PRE + 2;
    localparam int IDX_STO = N_PRE;
    localparam int IDX_REC = N_PRE + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GOT1,
        ST_GOT2,
        ST_GOT3,
        ST_GOT4,
        ST_GOT5
    } seq_state_t;

    // Keys 0..4 form the shared prefix; 5 selects store, 6 selects recall.
    function automatic logic [KEY_W-1:0] key_at(input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 14'h0E38;
            1:       k = 14'h31C7;
            2:       k = 14'h03E0;
            3:       k = 14'h3C1F;
            4:       k = 14'h303F;
            5:       k = 14'h0FC0;
            default: k = 14'h0C63;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/seqcmd_keymatch.sv
module seqcmd_keymatch
    import seqcmd_pkg::*;
#(
    parameter int NK = N_KEYS
) (
    input  logic [KEY_W-1:0] key_in,
    output logic [NK-1:0]    hit
);

    for (genvar i = 0; i < NK; i++) begin : g_key
        assign hit[i] = (key_in == key_at(i));
    end

endmodule

// File: rtl/seqcmd_fsm.sv
module seqcmd_fsm
    import seqcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              wr,
    input  logic [N_KEYS-1:0] hit,
    output logic              store_req,
    output logic              recall_req,
    output logic              seq_busy
);

    seq_state_t st, nxt;
    seq_state_t restart_st;
    logic       fire_sto, fire_rec;

    // A broken series may begin again on the same access.
    assign restart_st = hit[0] ? ST_GOT1 : ST_IDLE;

    always_comb begin
        nxt      = st;
        fire_sto = 1'b0;
        fire_rec = 1'b0;
        if (take) begin
            if (wr) begin
                nxt = ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: nxt = restart_st;
                    ST_GOT1: nxt = hit[1] ? ST_GOT2 : restart_st;
                    ST_GOT2: nxt = hit[2] ? ST_GOT3 : restart_st;
                    ST_GOT3: nxt = hit[3] ? ST_GOT4 : restart_st;
                    ST_GOT4: nxt = hit[4] ? ST_GOT5 : restart_st;
                    ST_GOT5: begin
                        if (hit[IDX_STO]) begin
                            fire_sto = 1'b1;
                            nxt      = ST_IDLE;
                        end else if (hit[IDX_REC]) begin
                            fire_rec = 1'b1;
                            nxt      = ST_IDLE;
                        end else begin
                            nxt = restart_st;
                        end
                    end
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
            seq_busy   <= 1'b0;
        end else begin
            store_req  <= fire_sto;
            recall_req <= fire_rec;
            seq_busy   <= (nxt != ST_IDLE);
        end
    end

endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_req,
    output logic              recall_req,
    output logic              seq_busy
);

    logic [N_KEYS-1:0] hit;
    logic              unused_hi;

    // Upper address bits take no part in matching.
    assign unused_hi = ^addr[ADDR_W-1:KEY_W];

    seqcmd_keymatch #(.NK(N_KEYS)) u_match (
        .key_in (addr[KEY_W-1:0]),
        .hit    (hit)
    );

    seqcmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (acc_stb && sel),
        .wr         (wr),
        .hit        (hit),
        .store_req  (store_req),
        .recall_req (recall_req),
        .seq_busy   (seq_busy)
    );

endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_stb,
    input logic sel,
    input logic wr,
    input logic store_req,
    input logic recall_req,
    input logic seq_busy
);

    a_r4_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && sel && wr) |=> (!seq_busy && !store_req && !recall_req));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_stb && sel) |=> ($stable(seq_busy) && !store_req && !recall_req));

    a_r8_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    a_r8_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    a_r8_idle_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> !seq_busy);

    a_r1_req_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(acc_stb && sel && !wr));

endmodule

bind seqcmd_detect seqcmd_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_stb    (acc_stb),
    .sel        (sel),
    .wr         (wr),
    .store_req  (store_req),
    .recall_req (recall_req),
    .seq_busy   (seq_busy)
);

// File: tb/seqcmd_detect_bench.sv
`timescale 1ns/1ps
module seqcmd_detect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [14:0] addr = '0;
    logic        store_req, recall_req, seq_busy;

    int checks = 0;
    int errors = 0;
    int prog = 0;
    bit exp_s, exp_r;
    bit done = 0;

    always #5 clk = ~clk;

    seqcmd_detect u_seqcmd_detect (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .sel(sel), .wr(wr),
        .addr(addr), .store_req(store_req), .recall_req(recall_req),
        .seq_busy(seq_busy)
    );

    function automatic logic [13:0] key(input int i);
        case (i)
            0: return 14'h0E38;
            1: return 14'h31C7;
            2: return 14'h03E0;
            3: return 14'h3C1F;
            4: return 14'h303F;
            5: return 14'h0FC0;
            default: return 14'h0C63;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check3(input string tag);
        chk(tag, "store_req", store_req, exp_s);
        chk(tag, "recall_req", recall_req, exp_r);
        chk(tag, "seq_busy", seq_busy, prog != 0);
    endtask

    // Drive one access, advance the expected model, then sample after the edge.
    task automatic access(input bit s, input bit w, input logic [14:0] a, input string tag);
        @(negedge clk);
        acc_stb = 1'b1; sel = s; wr = w; addr = a;
        exp_s = 0; exp_r = 0;
        if (s) begin
            if (w) prog = 0;
            else if (prog == 5 && a[13:0] == key(5)) begin exp_s = 1; prog = 0; end
            else if (prog == 5 && a[13:0] == key(6)) begin exp_r = 1; prog = 0; end
            else if (prog < 5 && a[13:0] == key(prog)) prog++;
            else prog = (a[13:0] == key(0)) ? 1 : 0;
        end
        @(negedge clk);
        acc_stb = 1'b0;
        check3(tag);
    endtask

    task automatic quiet(input string tag);
        @(negedge clk);
        exp_s = 0; exp_r = 0;
        check3(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; acc_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prog = 0; exp_s = 0; exp_r = 0;
        check3(tag);
        rst_n = 1'b1;
    endtask

    task automatic prefix(input bit hi, input int upto, input string tag);
        for (int i = 0; i < upto; i++) access(1, 0, {hi, key(i)}, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset("R9 reset state");

        // R1 store series
        prefix(0, 5, "R1 prefix");
        access(1, 0, {1'b0, key(5)}, "R1 store fire");
        quiet("R8 store pulse ends");

        // R2 recall series
        prefix(0, 5, "R2 prefix");
        access(1, 0, {1'b0, key(6)}, "R2 recall fire");
        quiet("R8 recall pulse ends");

        // R3 bit 14 ignored
        prefix(1, 5, "R3 prefix hi");
        access(1, 0, {1'b1, key(5)}, "R3 store with bit14");

        // R4 write aborts
        prefix(0, 3, "R4 prefix");
        access(1, 1, {1'b0, key(3)}, "R4 write abort");
        access(1, 0, {1'b0, key(3)}, "R4 no resume");

        // R6 deselected strobe and quiet cycles hold progress
        prefix(0, 2, "R6 prefix");
        access(0, 0, 15'h1234, "R6 deselected");
        access(0, 1, 15'h0000, "R6 deselected write");
        quiet("R6 quiet");
        for (int i = 2; i < 5; i++) access(1, 0, {1'b0, key(i)}, "R6 continue");
        access(1, 0, {1'b0, key(5)}, "R6 store after hold");

        // R5 restart on first key, wrong sixth key
        prefix(0, 4, "R5 prefix");
        access(1, 0, {1'b0, key(0)}, "R5 restart");
        for (int i = 1; i < 5; i++) access(1, 0, {1'b0, key(i)}, "R5 after restart");
        access(1, 0, 15'h0123, "R5 wrong sixth");
        access(1, 0, {1'b0, key(1)}, "R5 stays idle");
        prefix(0, 5, "R7 busy through prefix");
        access(1, 0, {1'b0, key(0)}, "R5 sixth is first key");

        // R9 reset mid-series
        do_reset("R9 reset mid series");

        // Random traffic for R1 R2 R3 R4 R5 R6 R7
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit s, w;
            logic [13:0] a;
            r = $urandom % 100;
            if (r < 65) a = (prog == 5) ? key(5 + ($urandom % 2)) : key(prog);
            else if (r < 75) a = key(0);
            else a = 14'($urandom);
            s = ($urandom % 10) != 0;
            w = ($urandom % 14) == 0;
            access(s, w, {1'($urandom), a}, "R7 random");
            if (($urandom % 8) == 0) quiet("R6 random quiet");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule